// File: doc/BRIEF.md
# Snooping Bus Memory Slave

This block is the memory-side target on a split-transaction shared bus. It takes request packets, reads from or writes to a small internal word store, and places the matching reply packets into an output queue. It answers read-block and write-shared traffic only after a fixed snoop window. Caches on the bus use that window to drive the wired shared and owner lines.

Every accepted request travels through a delay line that is `SNOOP_DLY` stages long. The request acts when it leaves the line. At that point the bus lines are sampled, the store or I/O register is touched, and at most one reply is pushed. A read-block is dropped without a reply if a cache claims ownership. A small window of I/O registers sits at the top of the address space. Acceptance is held off while the replies already queued, plus the requests still in the delay line, could fill the reply queue.

Top module: `bus_mem_slave`

## Requirements
- R1: After reset, `rply_valid` is 0 and `req_ready` is 1. The I/O registers read as 0.
- R2: A read-block request (code 0) replies with code 1. The reply carries the stored word at `addr[MEM_AW-1:0]`, and its shared flag equals `snp_shared` as sampled at the action edge.
- R3: If `snp_owner` is 1 at the action edge of a read-block request, no reply is produced.
- R4: A write-block (code 2) or flush-block (code 4) request stores `req_data` at the word index. It replies with flush-block reply code 5, shared flag 0 and data 0, whatever the shared line shows.
- R5: A write-shared request (code 6) replies with code 7. The reply carries the request data and the sampled shared flag.
- R6: A conditional write-shared request (code 8) replies with code 9. The reply carries the new value in `rply_data`, the old value in `rply_old`, and the sampled shared flag.
- R7: I/O read (10) and I/O write (12) requests act only when `addr[ADDR_W-1:IO_AW]` equals `IO_BASE`. A match replies with code 11 or 13, and a write updates the register before any later read. A request with no match gives no reply.
- R8: A broadcast I/O write (14) is always echoed as code 15 with its data. A demap request (18) is always answered with code 19 and data 0.
- R9: Reply codes (odd values) and map requests (16) produce no reply and leave the store unchanged.
- R10: Replies leave in request order. Each reply carries its requester's id and address, and its code is the request code with bit 0 set.
- R11: `req_ready` is 0 whenever queued replies plus requests in flight reach `FIFO_DEPTH`. A reply held by `rply_ready`=0 stays valid.
- R12: When the queue is empty, the reply becomes valid exactly `SNOOP_DLY` cycles after the edge that accepted its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request packet present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_cmd | input | 5 | Packet code |
| req_id | input | ID_W | Requester id |
| req_addr | input | ADDR_W | Real or I/O address |
| req_data | input | DATA_W | Data or new value |
| req_old | input | DATA_W | Old value for conditional write-shared |
| snp_shared | input | 1 | Wired shared line |
| snp_owner | input | 1 | Wired owner line |
| rply_valid | output | 1 | Reply at queue head |
| rply_ready | input | 1 | Consumer takes the reply |
| rply_cmd | output | 5 | Reply code |
| rply_id | output | ID_W | Requester id |
| rply_shared | output | 1 | Shared flag |
| rply_addr | output | ADDR_W | Address |
| rply_data | output | DATA_W | Reply data or new value |
| rply_old | output | DATA_W | Old value |

## Verification
A request accepted at edge E is acted on at edge E+`SNOOP_DLY`. The bench therefore schedules each request's shared and owner values for exactly the cycle that precedes that edge. It then expects the reply to become visible in the half cycle that follows. One directed check walks the cycles from E to E+`SNOOP_DLY` and requires `rply_valid` to be low until the last of them. Every other reply is compared by the scoreboard at the falling edge, plus 1 ns, of the cycle in which it is popped. Requests that give no reply are confirmed by the next expected reply arriving in sequence.

// File: rtl/bms_pkg.sv
package bms_pkg;
  localparam int CMD_W = 5;

  // requests are even, their replies are the next odd code
  typedef enum logic [CMD_W-1:0] {
    C_RD_BLK  = 5'd0,  C_RD_RPLY  = 5'd1,
    C_WR_BLK  = 5'd2,  C_WR_RPLY  = 5'd3,
    C_FL_BLK  = 5'd4,  C_FL_RPLY  = 5'd5,
    C_WS      = 5'd6,  C_WS_RPLY  = 5'd7,
    C_CWS     = 5'd8,  C_CWS_RPLY = 5'd9,
    C_IOR     = 5'd10, C_IOR_RPLY = 5'd11,
    C_IOW     = 5'd12, C_IOW_RPLY = 5'd13,
    C_BIOW    = 5'd14, C_BIOW_RPLY= 5'd15,
    C_MAP     = 5'd16, C_MAP_RPLY = 5'd17,
    C_DEMAP   = 5'd18, C_DEMAP_RPLY = 5'd19
  } bms_cmd_e;
endpackage

// File: rtl/bms_snoop_delay.sv
module bms_snoop_delay #(
  parameter int W   = 8,
  parameter int DLY = 4,
  localparam int OW = $clog2(DLY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [W-1:0]  in_pkt,
  output logic          out_vld,
  output logic [W-1:0]  out_pkt,
  output logic [OW-1:0] occ
);
  logic [DLY-1:0]        vld_q, vld_d;
  logic [DLY-1:0][W-1:0] pkt_q, pkt_d;

  for (genvar g = 0; g < DLY; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign vld_d[g] = in_vld;
      assign pkt_d[g] = in_pkt;
    end else begin : g_body
      assign vld_d[g] = vld_q[g-1];
      assign pkt_d[g] = pkt_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DLY; i++)
      if (vld_d[i]) pkt_q[i] <= pkt_d[i];
  end

  always_comb begin
    occ = '0;
    for (int i = 0; i < DLY; i++) occ = occ + OW'(vld_q[i]);
  end

  assign out_vld = vld_q[DLY-1];
  assign out_pkt = pkt_q[DLY-1];
endmodule

// File: rtl/bms_reply_fifo.sv
module bms_reply_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_pkt,
  input  logic          rd_rdy,
  output logic          out_vld,
  output logic [W-1:0]  out_pkt,
  output logic [CW-1:0] cnt
);
  logic [W-1:0]  store_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pop;

  assign out_vld = (cnt_q != '0);
  assign pop     = out_vld && rd_rdy;
  assign out_pkt = store_q[rp_q];
  assign cnt     = cnt_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store_q[wp_q] <= push_pkt;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CW'(DEPTH)));                                   // R11
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !rd_rdy) |=> (out_vld && $stable(out_pkt)));          // R11
endmodule

// File: rtl/bms_backing.sv
module bms_backing #(
  parameter int DATA_W = 32,
  parameter int MEM_AW = 4,
  parameter int IO_AW  = 2,
  localparam int MEM_N = 1 << MEM_AW,
  localparam int IO_N  = 1 << IO_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_we,
  input  logic [MEM_AW-1:0] mem_idx,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] mem_rdata,
  input  logic              io_we,
  input  logic [IO_AW-1:0]  io_idx,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata
);
  logic [DATA_W-1:0] word_q [MEM_N];
  logic [DATA_W-1:0] io_q   [IO_N];

  always_ff @(posedge clk) begin
    if (mem_we) word_q[mem_idx] <= mem_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < IO_N; i++) io_q[i] <= '0;
    end else if (io_we) begin
      io_q[io_idx] <= io_wdata;
    end
  end

  assign mem_rdata = word_q[mem_idx];
  assign io_rdata  = io_q[io_idx];
endmodule

// File: rtl/bus_mem_slave.sv
module bus_mem_slave
  import bms_pkg::*;
#(
  parameter int ID_W       = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int MEM_AW     = 4,
  parameter int IO_AW      = 2,
  parameter logic [ADDR_W-IO_AW-1:0] IO_BASE = '1,
  parameter int SNOOP_DLY  = 4,
  parameter int FIFO_DEPTH = 4,
  localparam int QW = CMD_W + ID_W + ADDR_W + 2 * DATA_W,
  localparam int RW = QW + 1,
  localparam int OW = $clog2(SNOOP_DLY + 1),
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [DATA_W-1:0] req_old,
  input  logic              snp_shared,
  input  logic              snp_owner,
  output logic              rply_valid,
  input  logic              rply_ready,
  output logic [CMD_W-1:0]  rply_cmd,
  output logic [ID_W-1:0]   rply_id,
  output logic              rply_shared,
  output logic [ADDR_W-1:0] rply_addr,
  output logic [DATA_W-1:0] rply_data,
  output logic [DATA_W-1:0] rply_old
);
  logic              x_vld;
  logic [QW-1:0]     x_pkt;
  logic [OW-1:0]     dly_occ;
  logic [CW-1:0]     fifo_cnt;
  logic [15:0]       pending;
  logic              accept;

  logic [CMD_W-1:0]  x_cmd;
  logic [ID_W-1:0]   x_id;
  logic [ADDR_W-1:0] x_addr;
  logic [DATA_W-1:0] x_data, x_old;
  logic              io_hit;

  logic              push;
  logic [CMD_W-1:0]  r_cmd;
  logic              r_shared;
  logic [DATA_W-1:0] r_data, r_old;
  logic              mem_we, io_we;
  logic [DATA_W-1:0] mem_rdata, io_rdata;
  logic [RW-1:0]     head_pkt;

  // space is reserved for every request still inside the snoop window
  assign pending   = 16'(fifo_cnt) + 16'(dly_occ);
  assign req_ready = (pending < 16'(FIFO_DEPTH));
  assign accept    = req_valid && req_ready;

  bms_snoop_delay #(.W(QW), .DLY(SNOOP_DLY)) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (accept),
    .in_pkt ({req_cmd, req_id, req_addr, req_data, req_old}),
    .out_vld(x_vld),
    .out_pkt(x_pkt),
    .occ    (dly_occ)
  );

  assign {x_cmd, x_id, x_addr, x_data, x_old} = x_pkt;
  assign io_hit = (x_addr[ADDR_W-1:IO_AW] == IO_BASE);

  always_comb begin
    push     = 1'b0;
    r_cmd    = x_cmd | CMD_W'(1);
    r_shared = 1'b0;
    r_data   = '0;
    r_old    = '0;
    mem_we   = 1'b0;
    io_we    = 1'b0;
    if (x_vld) begin
      case (x_cmd)
        C_RD_BLK: begin
          push     = !snp_owner;
          r_shared = snp_shared;
          r_data   = mem_rdata;
        end
        C_WR_BLK, C_FL_BLK: begin
          mem_we = 1'b1;
          push   = 1'b1;
          r_cmd  = C_FL_RPLY;
        end
        C_WS: begin
          push     = 1'b1;
          r_shared = snp_shared;
          r_data   = x_data;
        end
        C_CWS: begin
          push     = 1'b1;
          r_shared = snp_shared;
          r_data   = x_data;
          r_old    = x_old;
        end
        C_IOR: begin
          push   = io_hit;
          r_data = io_rdata;
        end
        C_IOW: begin
          push   = io_hit;
          io_we  = io_hit;
          r_data = x_data;
        end
        C_BIOW: begin
          push   = 1'b1;
          r_data = x_data;
        end
        C_DEMAP: push = 1'b1;
        default: push = 1'b0;
      endcase
    end
  end

  bms_backing #(.DATA_W(DATA_W), .MEM_AW(MEM_AW), .IO_AW(IO_AW)) u_back (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_we   (mem_we),
    .mem_idx  (x_addr[MEM_AW-1:0]),
    .mem_wdata(x_data),
    .mem_rdata(mem_rdata),
    .io_we    (io_we),
    .io_idx   (x_addr[IO_AW-1:0]),
    .io_wdata (x_data),
    .io_rdata (io_rdata)
  );

  bms_reply_fifo #(.W(RW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push),
    .push_pkt({r_cmd, x_id, r_shared, x_addr, r_data, r_old}),
    .rd_rdy  (rply_ready),
    .out_vld (rply_valid),
    .out_pkt (head_pkt),
    .cnt     (fifo_cnt)
  );

  assign {rply_cmd, rply_id, rply_shared, rply_addr, rply_data, rply_old} = head_pkt;

  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == CW'(FIFO_DEPTH)) |-> !req_ready);                    // R11
  AST_OWNER_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (x_vld && x_cmd == C_RD_BLK && snp_owner && !(rply_valid && rply_ready))
      |=> (fifo_cnt == $past(fifo_cnt)));                             // R3
  AST_REPLY_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    rply_valid |-> rply_cmd[0]);                                      // R10
  AST_FLUSH_UNSHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (rply_valid && rply_cmd == C_FL_RPLY) |-> !rply_shared);          // R4
endmodule

// File: tb/sim_bus_mem_slave.sv
module sim_bus_mem_slave;
  localparam int DLY   = 4;
  localparam int DEPTH = 4;

  typedef struct {
    logic [4:0]  cmd;
    logic [3:0]  id;
    logic        sh;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] old;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, snp_shared, snp_owner, rply_valid, rply_ready, rply_shared;
  logic [4:0]  req_cmd, rply_cmd;
  logic [3:0]  req_id, rply_id;
  logic [7:0]  req_addr, rply_addr;
  logic [31:0] req_data, req_old, rply_data, rply_old;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  exp_t expq[$];
  logic sh_at [8192];
  logic own_at[8192];
  logic [31:0] mem_m[16];
  logic [31:0] io_m[4];

  always #2.5 clk = ~clk;

  bus_mem_slave u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_id(req_id), .req_addr(req_addr), .req_data(req_data),
    .req_old(req_old), .snp_shared(snp_shared), .snp_owner(snp_owner),
    .rply_valid(rply_valid), .rply_ready(rply_ready), .rply_cmd(rply_cmd),
    .rply_id(rply_id), .rply_shared(rply_shared), .rply_addr(rply_addr),
    .rply_data(rply_data), .rply_old(rply_old)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    snp_shared = sh_at[cyc % 8192];
    snp_owner  = own_at[cyc % 8192];
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each popped reply against the scoreboard head (R10)
  always begin
    @(negedge clk);
    #1;
    if (rst_n && rply_valid && rply_ready) begin
      n_chk++;
      if (expq.size() == 0) begin
        n_bad++;
        $display("FAIL R10 unexpected reply actual cmd=%0d addr=%h expected none", rply_cmd, rply_addr);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if ({rply_cmd, rply_id, rply_shared, rply_addr, rply_data, rply_old} !==
            {e.cmd, e.id, e.sh, e.addr, e.data, e.old}) begin
          n_bad++;
          $display("FAIL R10 reply actual cmd=%0d id=%0d sh=%b a=%h d=%h o=%h expected cmd=%0d id=%0d sh=%b a=%h d=%h o=%h",
                   rply_cmd, rply_id, rply_shared, rply_addr, rply_data, rply_old,
                   e.cmd, e.id, e.sh, e.addr, e.data, e.old);
        end
      end
    end
  end

  // driver: computes the expected reply from the requirements and queues it
  task automatic send(input logic [4:0] cmd, input logic [3:0] id, input logic [7:0] addr,
                      input logic [31:0] data, input logic [31:0] old,
                      input logic sh, input logic own);
    exp_t e;
    logic rep;
    logic hit;
    @(negedge clk);
    req_valid = 1'b1; req_cmd = cmd; req_id = id; req_addr = addr;
    req_data = data;  req_old = old;
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    sh_at[(cyc + DLY) % 8192]  = sh;
    own_at[(cyc + DLY) % 8192] = own;
    hit = (addr[7:2] == 6'h3F);
    rep = 1'b0;
    e.cmd = cmd | 5'd1; e.id = id; e.sh = 1'b0; e.addr = addr; e.data = '0; e.old = '0;
    case (cmd)
      5'd0:  begin rep = !own; e.sh = sh; e.data = mem_m[addr[3:0]]; end     // R2 R3
      5'd2, 5'd4: begin rep = 1'b1; e.cmd = 5'd5; mem_m[addr[3:0]] = data; end // R4
      5'd6:  begin rep = 1'b1; e.sh = sh; e.data = data; end                  // R5
      5'd8:  begin rep = 1'b1; e.sh = sh; e.data = data; e.old = old; end     // R6
      5'd10: begin rep = hit; e.data = io_m[addr[1:0]]; end                   // R7
      5'd12: begin rep = hit; e.data = data; if (hit) io_m[addr[1:0]] = data; end
      5'd14: begin rep = 1'b1; e.data = data; end                             // R8
      5'd18: rep = 1'b1;
      default: rep = 1'b0;                                                    // R9
    endcase
    if (rep) expq.push_back(e);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (expq.size() != 0) @(negedge clk);
    repeat (DLY + 3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8192; i++) begin sh_at[i] = 1'b0; own_at[i] = 1'b0; end
    for (int i = 0; i < 16; i++) mem_m[i] = '0;
    for (int i = 0; i < 4; i++) io_m[i] = '0;
    rst_n = 1'b0; req_valid = 1'b0; rply_ready = 1'b1;
    req_cmd = '0; req_id = '0; req_addr = '0; req_data = '0; req_old = '0;
    snp_shared = 1'b0; snp_owner = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 rply_valid", 64'(rply_valid), 64'd0);
    check("R1 req_ready", 64'(req_ready), 64'd1);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4: stores with flush-block reply, shared forced low even with line high
    send(5'd2, 4'd1, 8'h03, 32'hA5A5_0003, '0, 1'b1, 1'b0);
    send(5'd4, 4'd2, 8'h05, 32'h5A5A_0005, '0, 1'b1, 1'b0);
    send(5'd2, 4'd3, 8'h07, 32'h1234_0007, '0, 1'b0, 1'b0);
    wait_idle();

    // R12: reply due exactly DLY cycles after the accepting edge
    send(5'd0, 4'd4, 8'h03, '0, '0, 1'b0, 1'b0);
    for (int k = 0; k <= DLY; k++) begin
      @(negedge clk);
      #1;
      check("R12 rply_valid timing", 64'(rply_valid), 64'(k == DLY));
    end
    wait_idle();

    // R2: read with shared sampled high; R3: owner suppresses the reply
    send(5'd0, 4'd5, 8'h05, '0, '0, 1'b1, 1'b0);
    send(5'd0, 4'd6, 8'h07, '0, '0, 1'b0, 1'b1);
    send(5'd0, 4'd7, 8'h07, '0, '0, 1'b1, 1'b0);
    // R5 and R6
    send(5'd6, 4'd8, 8'h21, 32'hCAFE_0001, '0, 1'b1, 1'b0);
    send(5'd6, 4'd9, 8'h22, 32'hCAFE_0002, '0, 1'b0, 1'b0);
    send(5'd8, 4'd10, 8'h23, 32'h0000_0111, 32'h0000_0222, 1'b1, 1'b0);
    wait_idle();

    // R7: I/O window at FC..FF
    send(5'd10, 4'd1, 8'hFE, '0, '0, 1'b0, 1'b0);
    send(5'd12, 4'd2, 8'hFD, 32'hBEEF_00FD, '0, 1'b0, 1'b0);
    send(5'd10, 4'd3, 8'hFD, '0, '0, 1'b0, 1'b0);
    send(5'd10, 4'd4, 8'h40, '0, '0, 1'b0, 1'b0);
    send(5'd12, 4'd5, 8'h41, 32'h0BAD_0041, '0, 1'b0, 1'b0);
    // R8
    send(5'd14, 4'd6, 8'h44, 32'h7777_0044, '0, 1'b1, 1'b0);
    send(5'd18, 4'd7, 8'h45, 32'h9999_9999, '0, 1'b1, 1'b0);
    wait_idle();

    // R9: replies and map request ignored; word 3 must still read back
    send(5'd3, 4'd1, 8'h03, 32'hDEAD_DEAD, '0, 1'b0, 1'b0);
    send(5'd1, 4'd1, 8'h03, 32'hDEAD_DEAD, '0, 1'b0, 1'b0);
    send(5'd5, 4'd1, 8'h03, 32'hDEAD_DEAD, '0, 1'b0, 1'b0);
    send(5'd16, 4'd1, 8'h03, 32'hDEAD_DEAD, '0, 1'b0, 1'b0);
    send(5'd0, 4'd2, 8'h03, '0, '0, 1'b0, 1'b0);
    wait_idle();

    // R11: hold the consumer, fill the queue, acceptance must stop
    @(posedge clk); #1 rply_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      send(5'd6, 4'(i), 8'(8'h60 + i), 32'(32'h600 + i), '0, 1'(i % 2), 1'b0);
    @(negedge clk); #1;
    check("R11 req_ready after fill", 64'(req_ready), 64'd0);
    repeat (DLY + 4) @(negedge clk);
    #1;
    check("R11 reply held valid", 64'(rply_valid), 64'd1);
    check("R11 req_ready still low", 64'(req_ready), 64'd0);
    @(posedge clk); #1 rply_ready = 1'b1;
    // R10: mixed back-to-back traffic behind the drain
    send(5'd0, 4'd12, 8'h05, '0, '0, 1'b0, 1'b0);
    send(5'd14, 4'd13, 8'h46, 32'h4646_4646, '0, 1'b0, 1'b0);
    send(5'd4, 4'd14, 8'h09, 32'h0909_0909, '0, 1'b0, 1'b0);
    send(5'd0, 4'd15, 8'h09, '0, '0, 1'b1, 1'b0);
    wait_idle();
    check("R10 scoreboard empty", 64'(expq.size()), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule